// File: doc/BRIEF.md
# T1/E1 System Frame Timing Mapper

This block is the system-side timing and channel-format stage that sits after a PCM elastic store. It keeps a bit position counter for the outgoing frame. That frame is 193 bits long at 1.544 MHz (T1) and 256 bits long at 2.048 MHz (E1). The counter runs freely once a single frame sync edge has aligned it. For every output bit position, the block chooses one of three sources: a bit read from the store, the framing bit, or a forced one. The choice depends on the rates selected separately for the receive side and the system side.

Reads from the store are made by address. The address is the bit index within the stored receive frame, so receive channels that the system frame has no room for are simply never addressed. A channel clock marks the channel slots of the system frame. In parallel-backplane mode, the data is looked ahead by eight bit positions, so that each channel's byte has been shifted out completely by the time its channel boundary arrives. The reset input `rst_ni` is asynchronous and is assumed to be released in step with `clk_i`.

Top module: `t1e1_frame_mapper`

## Requirements
- R1: The position counter runs 0..192 when `sys_e1_i`=0 and 0..255 when `sys_e1_i`=1. After the last position it returns to 0 without any sync pulse.
- R2: A cycle in which `fsync_i` is 1 and was 0 in the previous cycle is position 0. This re-aligns the counter at any point in the frame. A sync input held high does not re-align the counter again.
- R3: With `rx_e1_i`=0 and `sys_e1_i`=0 (T1 to T1), every position p reads the store with `rd_req_o`=1 and `rd_addr_o`=p. Position 0 therefore carries the received framing bit.
- R4: With `rx_e1_i`=1 and `sys_e1_i`=0, position 0 makes no read, and its output is forced to 1. Each position p from 1 to 192 reads address p-1. Addresses of 192 and above (receive channels 25 to 32) are never requested.
- R5: With `rx_e1_i`=0 and `sys_e1_i`=1, each position p below 192 reads address p+1, so the stored framing bit at address 0 is never read. Positions 192 to 255 make no read and are output as ones.
- R6: With `rx_e1_i`=1 and `sys_e1_i`=1, every position p reads address p.
- R7: `ser_o` in the cycle after a position equals the `rd_data_i` of that position's cycle if a read was made, and is 1 otherwise.
- R8: In the cycle after a position, `chclk_o` is 1 if that position is one of the first four bits of an 8-bit channel slot, and 0 otherwise. In T1 the slots start at position 1, and position 0 gives 0. In E1 the slots start at position 0. The channel clock always follows the true position.
- R9: With `par_mode_i`=1, the source selection and the read address for position p are those of position (p+8) modulo the frame length.
- R10: Any change of `rx_e1_i`, `sys_e1_i` or `par_mode_i` makes that same cycle position 0.
- R11: During reset, `ser_o`=1 and `chclk_o`=0. The first cycle after reset is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | System frame sync; a rising edge aligns the frame |
| rx_e1_i | input | 1 | Receive rate: 0 = 1.544 MHz T1, 1 = 2.048 MHz E1 |
| sys_e1_i | input | 1 | System rate: 0 = 1.544 MHz T1, 1 = 2.048 MHz E1 |
| par_mode_i | input | 1 | 1 = parallel backplane (8-bit look-ahead), 0 = serial |
| rd_data_i | input | 1 | Store bit at `rd_addr_o`, valid in the same cycle |
| rd_req_o | output | 1 | A store bit is used for the current position |
| rd_addr_o | output | 8 | Bit index within the stored receive frame |
| ser_o | output | 1 | Serial system data |
| chclk_o | output | 1 | Channel clock, high for the first half of each channel slot |

## Verification
`rd_req_o` and `rd_addr_o` are combinational from the position. They belong to the cycle in which the stimulus is applied: the sync edge, the configuration change, or the ordinary count step. `ser_o` and `chclk_o` pass through one register and belong to the following cycle. The bench drives its inputs at the falling edge. At each falling edge it first compares the registered outputs with the values it predicted one cycle earlier. It then applies the new inputs, waits one time unit, and compares the read request and address for the current position. A reference mapping, written directly from the requirements, is run for all eight combinations of rate and mode.

// File: rtl/t1e1_map_pkg.sv
package t1e1_map_pkg;
  localparam int unsigned CH_BITS   = 8;
  localparam int unsigned T1_CHANS  = 24;
  localparam int unsigned E1_CHANS  = 32;
  localparam int unsigned LOOKAHEAD = 8;
  localparam int unsigned T1_LEN    = T1_CHANS * CH_BITS + 1;
  localparam int unsigned E1_LEN    = E1_CHANS * CH_BITS;
  localparam int unsigned POS_W     = $clog2(E1_LEN);

  typedef struct packed {
    logic rx_e1;
    logic sys_e1;
    logic par;
  } map_cfg_t;
endpackage

// File: rtl/t1e1_pos_ctr.sv
module t1e1_pos_ctr #(
  parameter int unsigned POS_W  = 8,
  parameter int unsigned T1_LEN = 193,
  parameter int unsigned E1_LEN = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_e1_i,
  input  logic             restart_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_LEN - 1);
  localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_LEN - 1);

  logic [POS_W-1:0] pos_q, pos_d, last;

  always_comb begin
    last  = sys_e1_i ? E1_LAST : T1_LAST;
    pos_o = restart_i ? '0 : pos_q;
    pos_d = (pos_o == last) ? '0 : pos_o + POS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  // R1: position never leaves the frame of the selected system rate
  a_r1_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= last);

  // R2 / R10: a restart makes the next cycle position 1
  a_r2_restart_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pos_q == POS_W'(1)));
endmodule

// File: rtl/t1e1_slot_map.sv
module t1e1_slot_map
  import t1e1_map_pkg::*;
#(
  parameter int unsigned PW        = POS_W,
  parameter int unsigned CB        = CH_BITS,
  parameter int unsigned LEN_T1    = T1_LEN,
  parameter int unsigned LEN_E1    = E1_LEN,
  parameter int unsigned LOOK_BITS = LOOKAHEAD
) (
  input  logic          [PW-1:0] pos_i,
  input  map_cfg_t               cfg_i,
  output logic                   rd_req_o,
  output logic          [PW-1:0] rd_addr_o,
  output logic                   chclk_o
);
  localparam int unsigned LEN_W = PW + 1;
  localparam int unsigned CB_W  = $clog2(CB);

  logic [LEN_W-1:0] len, sum;
  logic [PW-1:0]    q, chan_idx;

  always_comb begin
    // look-ahead position for the parallel backplane
    len = cfg_i.sys_e1 ? LEN_W'(LEN_E1) : LEN_W'(LEN_T1);
    sum = {1'b0, pos_i} + LEN_W'(LOOK_BITS);
    if (sum >= len) sum = sum - len;
    q = cfg_i.par ? sum[PW-1:0] : pos_i;

    // source selection per system bit position
    rd_req_o  = 1'b0;
    rd_addr_o = '0;
    if (!cfg_i.sys_e1) begin
      if (q == '0) begin
        rd_req_o  = !cfg_i.rx_e1;
        rd_addr_o = '0;
      end else begin
        rd_req_o  = 1'b1;
        rd_addr_o = cfg_i.rx_e1 ? q - PW'(1) : q;
      end
    end else if (cfg_i.rx_e1) begin
      rd_req_o  = 1'b1;
      rd_addr_o = q;
    end else if (q < PW'(LEN_T1 - 1)) begin
      rd_req_o  = 1'b1;
      rd_addr_o = q + PW'(1);
    end

    // channel clock follows the true position
    chan_idx = cfg_i.sys_e1 ? pos_i : pos_i - PW'(1);
    chclk_o  = !(!cfg_i.sys_e1 && pos_i == '0) &&
               (chan_idx[CB_W-1:0] < CB_W'(CB / 2));
  end
endmodule

// File: rtl/t1e1_frame_mapper.sv
module t1e1_frame_mapper
  import t1e1_map_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             rx_e1_i,
  input  logic             sys_e1_i,
  input  logic             par_mode_i,
  input  logic             rd_data_i,
  output logic             rd_req_o,
  output logic [POS_W-1:0] rd_addr_o,
  output logic             ser_o,
  output logic             chclk_o
);
  map_cfg_t         cfg, cfg_q;
  logic             fsync_q, sync_edge, cfg_chg, restart;
  logic [POS_W-1:0] pos;
  logic             map_ch, ser_d;

  always_comb begin
    cfg.rx_e1  = rx_e1_i;
    cfg.sys_e1 = sys_e1_i;
    cfg.par    = par_mode_i;
    sync_edge  = fsync_i && !fsync_q;
    cfg_chg    = (cfg != cfg_q);
    restart    = sync_edge || cfg_chg;
  end

  t1e1_pos_ctr #(
    .POS_W (POS_W),
    .T1_LEN(T1_LEN),
    .E1_LEN(E1_LEN)
  ) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sys_e1_i (sys_e1_i),
    .restart_i(restart),
    .pos_o    (pos)
  );

  t1e1_slot_map u_map (
    .pos_i    (pos),
    .cfg_i    (cfg),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .chclk_o  (map_ch)
  );

  always_comb ser_d = rd_req_o ? rd_data_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q <= 1'b1;
      cfg_q   <= '0;
      ser_o   <= 1'b1;
      chclk_o <= 1'b0;
    end else begin
      fsync_q <= fsync_i;
      cfg_q   <= cfg;
      ser_o   <= ser_d;
      chclk_o <= map_ch;
    end
  end

  // R7: positions without a read come out as ones
  a_r7_forced_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_o |=> ser_o);

  // R7: read data reaches the line one cycle later
  a_r7_pass_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> (ser_o == $past(rd_data_i)));

  // R6: E1 to E1 reads every position
  a_r6_all_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_e1_i && sys_e1_i) |-> rd_req_o);

  // R4: receive channels beyond 24 are never addressed on a T1 system side
  a_r4_drop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rx_e1_i && !sys_e1_i) |-> (rd_addr_o < POS_W'(T1_LEN - 1)));

  // R5: the stored framing bit is never read on an E1 system side
  a_r5_no_fbit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rx_e1_i && sys_e1_i) |-> (rd_addr_o != '0));
endmodule

// File: tb/tb_t1e1_frame_mapper.sv
module tb_t1e1_frame_mapper;
  import t1e1_map_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_CFG      = 8;
  // entry: {rx_e1, sys_e1, par, expected frame length}
  localparam logic [11:0] TAB [N_CFG] = '{
    {3'b010, 9'd256}, {3'b100, 9'd193}, {3'b110, 9'd256}, {3'b001, 9'd193},
    {3'b111, 9'd256}, {3'b011, 9'd256}, {3'b101, 9'd193}, {3'b000, 9'd193}
  };

  logic             clk, rst_n, fsync, rx, sy, pa, rd_data, rd_req, ser, chclk;
  logic [POS_W-1:0] rd_addr;
  int               checks, errors, p, tlen;
  logic [2:0]       tc;
  logic             exp_ser, exp_ch;
  bit               have_exp, done;

  t1e1_frame_mapper dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .fsync_i   (fsync),
    .rx_e1_i   (rx),
    .sys_e1_i  (sy),
    .par_mode_i(pa),
    .rd_data_i (rd_data),
    .rd_req_o  (rd_req),
    .rd_addr_o (rd_addr),
    .ser_o     (ser),
    .chclk_o   (chclk)
  );

  function automatic logic buf_bit(input logic [POS_W-1:0] a);
    return a[7] ^ a[5] ^ a[4] ^ a[2] ^ a[0];
  endfunction

  assign rd_data = buf_bit(rd_addr);

  function automatic void ref_map(input logic r, input logic s, input int q,
                                  output bit req, output int addr);
    req = 0; addr = 0;
    if (!s) begin
      if (q == 0) begin req = !r; addr = 0; end
      else begin req = 1; addr = r ? q - 1 : q; end
    end else if (r) begin req = 1; addr = q; end
    else if (q < 192) begin req = 1; addr = q + 1; end
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_cycle(input logic fs, input logic [2:0] c, input int len,
                          input bit restart, input string tag);
    int    q;
    bit    e_req;
    int    e_addr;
    string mtag;
    @(negedge clk);
    if (have_exp) begin
      chk(ser === exp_ser, "R7", "ser_o", ser, exp_ser);
      chk(chclk === exp_ch, "R8", "chclk_o", chclk, exp_ch);
    end
    rst_n = 1'b1;
    fsync = fs;
    {rx, sy, pa} = c;
    if (restart) p = 0;
    else         p = (p + 1) % len;
    #1;
    q = pa ? (p + 8) % len : p;
    ref_map(rx, sy, q, e_req, e_addr);
    if (tag != "")      mtag = tag;
    else if (p == 0)    mtag = "R1";
    else if (pa)        mtag = "R9";
    else if (!rx && !sy) mtag = "R3";
    else if (rx && !sy) mtag = "R4";
    else if (!rx && sy) mtag = "R5";
    else                mtag = "R6";
    chk(rd_req === e_req, mtag, "rd_req_o", rd_req, e_req);
    if (e_req) chk(rd_addr == POS_W'(e_addr), mtag, "rd_addr_o", rd_addr, e_addr);
    exp_ser  = e_req ? buf_bit(POS_W'(e_addr)) : 1'b1;
    exp_ch   = sy ? ((p % 8) < 4) : (p != 0 && ((p - 1) % 8) < 4);
    have_exp = 1;
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; p = 0; have_exp = 0; done = 0;
    rst_n = 1'b0; fsync = 1'b0; rx = 1'b0; sy = 1'b0; pa = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser === 1'b1, "R11", "ser_o in reset", ser, 1);
    chk(chclk === 1'b0, "R11", "chclk_o in reset", chclk, 0);
    do_cycle(1'b0, 3'b000, 193, 1, "R11");
    // free-running T1/T1 frame with no sync: wrap back to 0 (R1)
    repeat (200) do_cycle(1'b0, 3'b000, 193, 0, "");
    for (int i = 0; i < N_CFG; i++) begin
      tc   = TAB[i][11:9];
      tlen = int'(TAB[i][8:0]);
      do_cycle(1'b0, tc, tlen, 1, "R10");
      repeat (4) do_cycle(1'b0, tc, tlen, 0, "");
      do_cycle(1'b1, tc, tlen, 1, "R2");
      repeat (2) do_cycle(1'b1, tc, tlen, 0, "R2");
      repeat (2 * tlen) do_cycle(1'b0, tc, tlen, 0, "");
    end
    do_cycle(1'b0, tc, tlen, 0, "");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule